// File: doc/BRIEF.md
# Reference-Timed Clock Loss Detector

This block watches a monitored system clock from a second, free-running reference clock and raises a reset request when the monitored clock stops producing edges for longer than a programmable window. Each rising edge of the monitored clock flips a one-bit flag. Two flip-flops carry that flag into the reference domain. When a change in the synchronised flag is seen, the reference-domain silence counter restarts. The silence counter runs only on the reference clock, so the timeout is still measured when the monitored clock has stopped completely.

An enable input controls detection. When enable is low, the block never requests a reset. A stop-mode indication, synchronous to the reference clock, reports that the monitored clock is being halted on purpose. If enable is high at that moment, a reset is requested at once, so software can use stop mode to force a reset.

A small state machine holds the detector state. IDLE means detection is off. WATCH means the silence counter is running. TRIP means the reset request is driven. The transitions are:
- IDLE to WATCH when enable is seen high.
- WATCH to IDLE or TRIP to IDLE when enable is seen low.
- WATCH to TRIP on expiry of the silence window or on stop mode.
- TRIP to WATCH when a monitored edge is recognised.

Top module: `clk_loss_monitor`

## Requirements
- R1: While ref_rst_n is low, rst_req is 0 and the state is IDLE. After release, the block stays IDLE with rst_req at 0 until enable is sampled high.
- R2: From the first reference rising edge at which enable is sampled 0, rst_req is 0. It stays 0 while enable is 0, whatever mon_clk and stop_mode do.
- R3: In WATCH, if TIMEOUT_CYC consecutive reference cycles pass with no recognised monitored edge, the state moves to TRIP on the next reference edge. Entering WATCH from IDLE starts a full window, so with no monitored edges rst_req rises on the TIMEOUT_CYC-th reference rising edge after the edge that entered WATCH.
- R4: A monitored clock whose rising edges are at most TIMEOUT_CYC reference cycles apart never causes a request.
- R5: A monitored clock whose rising edges are TIMEOUT_CYC+1 or more reference cycles apart always causes a request. This includes rates many times slower.
- R6: A mon_clk rising edge is recognised on the third reference rising edge after it: two synchronising stages, then a compare. A clock that halts after an edge raises rst_req on the (TIMEOUT_CYC+3)-th reference rising edge after its last edge.
- R7: If stop_mode (1 = entering stop) is sampled high while the state is WATCH and enable is 1, rst_req is 1 from that reference edge on.
- R8: Once asserted, rst_req stays 1 until a monitored edge is recognised, enable goes low, or reset is applied. On a recognised edge it drops at that reference edge, and a fresh full window starts in WATCH.
- R9: Asserting ref_rst_n low clears rst_req at once, without waiting for a reference clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock that times the window |
| ref_rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| mon_clk | input | 1 | Clock under supervision |
| enable | input | 1 | 1 = detection on, 0 = no request is ever raised |
| stop_mode | input | 1 | 1 = monitored clock being halted on purpose; synchronous to ref_clk |
| rst_req | output | 1 | 1 = reset requested (state TRIP) |

## Verification
The bench drives monitored clocks whose edge spacing sits exactly on the threshold (TIMEOUT_CYC cycles) and one cycle past it. A window that is off by one in either direction trips on the fast case or stays quiet on the slow one.

A single isolated monitored edge is used to time both the recognition latency and the halted-clock trip to the exact reference cycle. A design with a missing or extra synchroniser stage, or a counter that does not restart on recognition, lands a cycle off.

Stop mode is applied both with enable set and with enable clear. This exposes a design that ignores stop or trips while disabled.

Clearing enable during a request and pulsing reset during a request show whether the request drops when it should. A design that latches the request forever, or that releases it only on a clock edge, fails here.

// File: rtl/clk_loss_pkg.sv
package clk_loss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_TRIP  = 2'd2
    } mon_state_t;

endpackage

// File: rtl/clk_loss_toggle.sv
// Monitored-clock domain: one flag that flips on every rising edge.
module clk_loss_toggle (
    input  logic mon_clk,
    input  logic arst_n,
    output logic tog
);

    always_ff @(posedge mon_clk or negedge arst_n) begin
        if (!arst_n) begin
            tog <= 1'b0;
        end else begin
            tog <= ~tog;
        end
    end

endmodule

// File: rtl/clk_loss_sync.sv
// Carries the toggle flag into the reference domain and reports a change.
module clk_loss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic edge_seen
);

    logic [STAGES:0] chain;

    // Stages 0..STAGES-1 synchronise; stage STAGES holds the previous value.
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    chain[0] <= 1'b0;
                end else begin
                    chain[0] <= din;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    chain[i] <= 1'b0;
                end else begin
                    chain[i] <= chain[i-1];
                end
            end
        end
    end

    assign edge_seen = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/clk_loss_window.sv
// Silence counter on the reference clock.
module clk_loss_window #(
    parameter int TIMEOUT_CYC = 32,
    parameter int CNT_W       = 5
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             clear,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    assign expire = (cnt == LAST);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/clk_loss_fsm.sv
// IDLE / WATCH / TRIP control.
module clk_loss_fsm
    import clk_loss_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       enable,
    input  logic       stop_mode,
    input  logic       edge_seen,
    input  logic       expire,
    output mon_state_t state,
    output logic       rst_req
);

    mon_state_t state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (enable) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (!enable)        state_d = ST_IDLE;
                else if (stop_mode) state_d = ST_TRIP;
                else if (edge_seen) state_d = ST_WATCH;
                else if (expire)    state_d = ST_TRIP;
            end
            ST_TRIP: begin
                if (!enable)        state_d = ST_IDLE;
                else if (edge_seen) state_d = ST_WATCH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        rst_req = (state == ST_TRIP);
    end

endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
    import clk_loss_pkg::*;
#(
    parameter int TIMEOUT_CYC = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic mon_clk,
    input  logic enable,
    input  logic stop_mode,
    output logic rst_req
);

    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;

    logic             tog;
    logic             edge_seen;
    logic             expire;
    logic             win_clear;
    logic [CNT_W-1:0] win_cnt;
    mon_state_t       state_q;

    clk_loss_toggle u_tog (
        .mon_clk (mon_clk),
        .arst_n  (ref_rst_n),
        .tog     (tog)
    );

    clk_loss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (ref_clk),
        .arst_n    (ref_rst_n),
        .din       (tog),
        .edge_seen (edge_seen)
    );

    assign win_clear = (state_q != ST_WATCH) || edge_seen;

    clk_loss_window #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_win (
        .clk    (ref_clk),
        .arst_n (ref_rst_n),
        .clear  (win_clear),
        .expire (expire),
        .cnt    (win_cnt)
    );

    clk_loss_fsm u_fsm (
        .clk       (ref_clk),
        .arst_n    (ref_rst_n),
        .enable    (enable),
        .stop_mode (stop_mode),
        .edge_seen (edge_seen),
        .expire    (expire),
        .state     (state_q),
        .rst_req   (rst_req)
    );

endmodule

// File: rtl/clk_loss_monitor_chk.sv
module clk_loss_monitor_chk
    import clk_loss_pkg::*;
#(
    parameter int TIMEOUT_CYC = 32,
    parameter int CNT_W       = 5
) (
    input logic             ref_clk,
    input logic             ref_rst_n,
    input logic             enable,
    input logic             stop_mode,
    input logic             rst_req,
    input logic             edge_seen,
    input mon_state_t       state,
    input logic [CNT_W-1:0] cnt
);

    int quiet;

    // Enabled cycles with no recognised edge and no request.
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            quiet <= 0;
        end else if (!enable || edge_seen || rst_req) begin
            quiet <= 0;
        end else begin
            quiet <= quiet + 1;
        end
    end

    always @(negedge ref_clk) begin
        if (!ref_rst_n) begin
            a_r1_quiet_in_reset: assert (!rst_req && state == ST_IDLE);
        end
    end

    a_r2_disable_drops: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !enable |=> !rst_req);

    a_r3_count_in_range: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        int'(cnt) < TIMEOUT_CYC);

    a_r3_silence_bounded: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        quiet <= TIMEOUT_CYC + 1);

    a_r7_stop_trips: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (state == ST_WATCH && enable && stop_mode) |=> rst_req);

    a_r8_request_held: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (rst_req && enable && !edge_seen) |=> rst_req);

    a_r8_release_cause: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(rst_req) |-> $past(!enable || edge_seen));

endmodule

bind clk_loss_monitor clk_loss_monitor_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
) u_chk (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .enable    (enable),
    .stop_mode (stop_mode),
    .rst_req   (rst_req),
    .edge_seen (edge_seen),
    .state     (state_q),
    .cnt       (win_cnt)
);

// File: tb/clk_loss_monitor_test.sv
module clk_loss_monitor_test;

    localparam int PERIOD = 10;
    localparam int TO     = 32;

    logic ref_clk = 1'b0;
    logic ref_rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic enable = 1'b0;
    logic stop_mode = 1'b0;
    logic rst_req;

    int n_chk = 0;
    int n_err = 0;
    int mon_period = 0;
    int mcnt = 0;
    logic tb_tog = 1'b0;
    logic seen_req = 1'b0;
    bit done = 0;

    // Reference model state: 0 idle, 1 watch, 2 trip
    int m_st = 0;
    int m_cnt = 0;
    logic d1 = 0, d2 = 0, d3 = 0;

    clk_loss_monitor #(.TIMEOUT_CYC(TO), .SYNC_STAGES(2)) uut (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .mon_clk   (mon_clk),
        .enable    (enable),
        .stop_mode (stop_mode),
        .rst_req   (rst_req)
    );

    always #(PERIOD/2) ref_clk = ~ref_clk;

    // Monitored clock: one rising edge every mon_period reference cycles, at ref falling edges
    always @(negedge ref_clk) begin
        logic nxt;
        nxt = 1'b0;
        if (!ref_rst_n) begin
            mcnt = 0;
            tb_tog = 1'b0;
        end else if (mon_period > 0) begin
            mcnt = mcnt + 1;
            if (mcnt >= mon_period) begin
                mcnt = 0;
                nxt = 1'b1;
                tb_tog = ~tb_tog;
            end
        end else begin
            mcnt = 0;
        end
        mon_clk = nxt;
    end

    // Behavioural reference: an edge acts three reference edges after it happens
    always @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            m_st = 0; m_cnt = 0; d1 = 0; d2 = 0; d3 = 0;
        end else begin
            logic e;
            e = d2 ^ d3;
            case (m_st)
                0: if (enable) begin m_st = 1; m_cnt = 0; end
                1: begin
                    if (!enable) begin m_st = 0; m_cnt = 0; end
                    else if (stop_mode) begin m_st = 2; end
                    else if (e) m_cnt = 0;
                    else if (m_cnt == TO - 1) m_st = 2;
                    else m_cnt = m_cnt + 1;
                end
                default: begin
                    m_cnt = 0;
                    if (!enable) m_st = 0;
                    else if (e) m_st = 1;
                end
            endcase
            d3 = d2; d2 = d1; d1 = tb_tog;
        end
    end

    always @(posedge ref_clk) begin
        #2;
        n_chk++;
        if (rst_req !== (m_st == 2)) begin
            n_err++;
            $display("FAIL R3/R6 model at %0t: rst_req=%0b expected %0b", $time, rst_req, (m_st == 2));
        end
        if (rst_req === 1'b1) seen_req = 1'b1;
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge ref_clk); #4; end
    endtask

    task automatic look(input logic exp, input string tag);
        @(posedge ref_clk); #2;
        chk(rst_req, exp, tag);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        step(4);
        look(1'b0, "R1 request low in reset");
        step(1); ref_rst_n = 1'b1;
        step(3);
        look(1'b0, "R1 idle after release");

        // R2: disabled with a dead clock
        step(60);
        look(1'b0, "R2 no request while disabled");

        // R3: full window from IDLE with no monitored edges
        step(1); enable = 1'b1;
        repeat (TO) @(posedge ref_clk);
        #2 chk(rst_req, 1'b0, "R3 window not yet over");
        @(posedge ref_clk);
        #2 chk(rst_req, 1'b1, "R3 trip after window");

        // R8: held while the clock stays dead, then released
        step(20);
        look(1'b1, "R8 request held");
        step(1); mon_period = 4;
        step(12);
        look(1'b0, "R8 released by edges");

        // R4: fast clocks never flagged, including the exact boundary
        step(1); mon_period = 20; seen_req = 1'b0;
        step(200);
        chk(seen_req, 1'b0, "R4 spacing 20 quiet");
        mon_period = TO; seen_req = 1'b0;
        step(300);
        chk(seen_req, 1'b0, "R4 spacing at window quiet");

        // R5: one cycle past the window, and a far slower clock
        mon_period = TO + 1; seen_req = 1'b0;
        step(200);
        chk(seen_req, 1'b1, "R5 spacing window+1 flagged");
        mon_period = 4;
        step(30);
        mon_period = 200; seen_req = 1'b0;
        step(500);
        chk(seen_req, 1'b1, "R5 very slow clock flagged");

        // R6: single edge, exact latency and halted-clock trip
        mon_period = 0;
        step(TO + 10);
        look(1'b1, "R6 tripped before pulse");
        step(1); mon_period = 1;
        @(posedge ref_clk); #4 mon_period = 0;
        @(posedge ref_clk); #2 chk(rst_req, 1'b1, "R6 edge not yet recognised");
        @(posedge ref_clk); #2 chk(rst_req, 1'b0, "R6 edge recognised on third ref edge");
        repeat (TO - 1) @(posedge ref_clk);
        #2 chk(rst_req, 1'b0, "R6 one cycle before halted trip");
        @(posedge ref_clk);
        #2 chk(rst_req, 1'b1, "R6 halted trip at window+3");

        // R7: stop mode with enable set
        step(1); mon_period = 4;
        step(12);
        look(1'b0, "R7 healthy before stop");
        step(1); stop_mode = 1'b1;
        look(1'b1, "R7 stop trips at once");
        step(1); stop_mode = 1'b0;
        step(12);
        look(1'b0, "R8 recovery after stop");

        // R7/R2: stop with enable clear does nothing
        step(1); enable = 1'b0;
        step(2); stop_mode = 1'b1; mon_period = 0;
        step(TO + 10);
        look(1'b0, "R2 stop while disabled ignored");
        step(1); stop_mode = 1'b0;

        // R2: clearing enable drops a live request
        step(1); enable = 1'b1;
        step(TO + 10);
        look(1'b1, "R2 request up before disable");
        step(1); enable = 1'b0;
        look(1'b0, "R2 request dropped on disable");

        // R9: asynchronous reset clears a live request
        step(1); enable = 1'b1;
        step(TO + 10);
        look(1'b1, "R9 request up before reset");
        @(posedge ref_clk); #4 ref_rst_n = 1'b0;
        #1 chk(rst_req, 1'b0, "R9 reset clears at once");
        step(3); ref_rst_n = 1'b1; enable = 1'b0;
        step(5);
        look(1'b0, "R1 idle after second reset");
        report();
    end

endmodule